// File: doc/BRIEF.md
# Dual-Bank Direct Digital Synthesis Waveform Core

This core is the digital heart of a direct digital synthesizer. A 28-bit phase accumulator advances once per master clock by a frequency tuning word, so the output repeats at `word * f_clk / 2^28`; for example, the word 0x2492492 with a 16 MHz clock gives roughly 2.28 MHz. The top 12 bits of the accumulator are offset by a phase word. The result drives either a sine shaper, built from a quarter-wave table that is mirrored by quadrant, or a triangle folder. A 10-bit offset-binary sample comes out every cycle.

Two frequency words and two phase words are held on chip. A pin of each kind picks the active word on every clock edge, which allows frequency and phase keying. A control register bit can instead hand the choice to software. A square output follows the accumulator MSB, either directly or halved by a toggle stage.

The core loads its registers through a simple parallel write port. A synchronous accumulator clear parks the output at mid-scale without losing the stored words. A sleep input freezes the whole datapath until it is released.

Top module: `dds_wave_core`

## Requirements
- R1: While `rst_n` is low, every stored word, the control register, the accumulator and the toggle stage are cleared, `sample` is 512 and `sq_out` is 0.
- R2: On each clock edge with neither `acc_clr` nor `sleep` high, the accumulator becomes its old value plus the selected frequency word, modulo 2^28. `sample` is computed from the accumulator value held before that edge.
- R3: With control bit 0 clear, `freq_pin` = 1 selects frequency word 1 (and 0 selects word 0). `phase_pin` selects phase word 1 or 0 in the same way. Each pin is sampled at the clock edge that uses it.
- R4: With control bit 0 set, control bit 1 selects the frequency word and control bit 2 selects the phase word, and both pins are ignored.
- R5: The phase index is accumulator bits [27:16] plus the selected 12-bit phase word, modulo 4096.
- R6: With control bit 3 clear (sine), `sample` = 512 + round(511*sin(2*pi*(p+0.5)/4096)) within +/-2 LSB, where p is the phase index.
- R7: With control bit 3 set (triangle), `sample` = p[10:1] when p[11] is 0, and the bitwise inverse of p[10:1] when p[11] is 1.
- R8: With control bit 4 clear, `sq_out` after an edge equals accumulator bit 27 as it was before that edge.
- R9: With control bit 4 set, `sq_out` after an edge equals the toggle stage as it was before that edge. The toggle stage flips on each edge where accumulator bit 27 goes from 0 to 1, so it runs at half the MSB rate.
- R10: `acc_clr` high at an edge zeroes the accumulator and the toggle stage, sets `sample` to 512 and `sq_out` to 0, and keeps all stored words. It takes priority over `sleep`.
- R11: `sleep` high (with `acc_clr` low) holds the accumulator, the toggle stage, `sample` and `sq_out`. Accumulation resumes from the held phase on release.
- R12: With `wr_en` high, `wr_addr` 0 and 1 load frequency words 0 and 1 from `wr_data[27:0]`. Addresses 2 and 3 load phase words 0 and 1 from `wr_data[11:0]`, and address 4 loads the control register from `wr_data[15:0]`. Addresses 5 to 7 change nothing. A write takes effect at the edge, whatever the state of `sleep` or `acc_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for a write |
| wr_data | input | 28 | Write data |
| freq_pin | input | 1 | Frequency word select pin |
| phase_pin | input | 1 | Phase word select pin |
| acc_clr | input | 1 | Synchronous accumulator clear and mid-scale hold |
| sleep | input | 1 | Freeze the datapath |
| sample | output | 10 | Offset-binary waveform sample |
| sq_out | output | 1 | Square output from the accumulator MSB |

## Verification
The assertions take for granted that the select pins, `sleep`, `acc_clr` and the write port only change away from the rising clock edge. They also assume `rst_n` is released synchronously, so each `$past` term sees a settled value. The bench drives every input on the falling edge and samples the outputs on the next falling edge. It keeps the control register's reserved bits at zero, so the only mode changes are the ones the requirements define.

// File: rtl/dds_wave_pkg.sv
package dds_wave_pkg;

    localparam int CTRL_W = 16;

    typedef enum logic [2:0] {
        ADDR_FREQ0  = 3'd0,
        ADDR_FREQ1  = 3'd1,
        ADDR_PHASE0 = 3'd2,
        ADDR_PHASE1 = 3'd3,
        ADDR_CTRL   = 3'd4
    } reg_addr_e;

    // Control word, bit 0 is sw_sel
    typedef struct packed {
        logic [CTRL_W-6:0] rsvd;
        logic              sq_div2;   // bit 4
        logic              tri_mode;  // bit 3
        logic              p_sw;      // bit 2
        logic              f_sw;      // bit 1
        logic              sw_sel;    // bit 0
    } ctrl_t;

    // Quarter-wave magnitude, rational sine approximation at half-step centres
    function automatic int quarter_amp(int idx, int qbits, int amp);
        longint d;
        longint u;
        longint w;
        longint num;
        longint den;
        d   = longint'(1) <<< (qbits + 2);
        u   = 2 * longint'(idx) + 1;
        w   = u * (d - u);
        num = 16 * longint'(amp) * w;
        den = 5 * d * d - 4 * w;
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_wave_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             freq_pin,
    input  logic             phase_pin,
    output logic [ACC_W-1:0] freq_word,
    output logic [PH_W-1:0]  phase_word,
    output ctrl_t            ctrl
);

    typedef struct packed {
        logic [ACC_W-1:0] f0;
        logic [ACC_W-1:0] f1;
        logic [PH_W-1:0]  p0;
        logic [PH_W-1:0]  p1;
        ctrl_t            ctrl;
    } bank_t;

    bank_t st_d, st_q;
    logic  fsel, psel;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_FREQ0:  st_d.f0   = wr_data;
                ADDR_FREQ1:  st_d.f1   = wr_data;
                ADDR_PHASE0: st_d.p0   = wr_data[PH_W-1:0];
                ADDR_PHASE1: st_d.p1   = wr_data[PH_W-1:0];
                ADDR_CTRL:   st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                default:     st_d      = st_q;
            endcase
        end
        fsel       = st_q.ctrl.sw_sel ? st_q.ctrl.f_sw : freq_pin;
        psel       = st_q.ctrl.sw_sel ? st_q.ctrl.p_sw : phase_pin;
        freq_word  = fsel ? st_q.f1 : st_q.f0;
        phase_word = psel ? st_q.p1 : st_q.p0;
        ctrl       = st_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_write_f1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_FREQ1) |=> (st_q.f1 == $past(wr_data)));

    p_ignored_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_CTRL) |=> $stable(st_q));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_clr,
    input  logic             sleep,
    input  logic             sq_div2,
    input  logic [ACC_W-1:0] freq_word,
    output logic [ACC_W-1:0] acc,
    output logic             sq_out
);

    localparam int MSB = ACC_W - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tog;
        logic             sq;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] acc_nxt;

    always_comb begin
        st_d    = st_q;
        acc_nxt = st_q.acc + freq_word;
        if (acc_clr) begin
            st_d = '0;
        end else if (!sleep) begin
            st_d.acc = acc_nxt;
            st_d.tog = st_q.tog ^ (~st_q.acc[MSB] & acc_nxt[MSB]);
            st_d.sq  = sq_div2 ? st_q.tog : st_q.acc[MSB];
        end
        acc    = st_q.acc;
        sq_out = st_q.sq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc == '0 && !sq_out));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !sleep) |=> (acc == ACC_W'($past(acc) + $past(freq_word))));

    p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !acc_clr) |=> ($stable(acc) && $stable(sq_out)));

    p_sq_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !sleep && !sq_div2) |=> (sq_out == $past(acc[MSB])));

endmodule

// File: rtl/dds_wave_shaper.sv
module dds_wave_shaper
    import dds_wave_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_clr,
    input  logic             sleep,
    input  logic             tri_mode,
    input  logic [PH_W-1:0]  acc_top,
    input  logic [PH_W-1:0]  phase_off,
    output logic [OUT_W-1:0] sample
);

    localparam int QB    = PH_W - 2;
    localparam int QN    = 1 << QB;
    localparam int MAG_W = OUT_W - 1;
    localparam int AMP   = (1 << MAG_W) - 1;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1 << MAG_W);

    logic [MAG_W-1:0] rom [QN];

    for (genvar gi = 0; gi < QN; gi++) begin : g_rom
        assign rom[gi] = MAG_W'(quarter_amp(gi, QB, AMP));
    end

    typedef struct packed {
        logic [OUT_W-1:0] smp;
    } shp_st_t;

    shp_st_t st_d, st_q;
    logic [PH_W-1:0]  addr;
    logic [QB-1:0]    qidx;
    logic [MAG_W-1:0] mag;
    logic [OUT_W-1:0] sine_v, tri_v;

    always_comb begin
        st_d   = st_q;
        addr   = acc_top + phase_off;
        qidx   = addr[PH_W-2] ? ~addr[QB-1:0] : addr[QB-1:0];
        mag    = rom[qidx];
        sine_v = addr[PH_W-1] ? (MID - {1'b0, mag}) : (MID + {1'b0, mag});
        tri_v  = addr[PH_W-1] ? ~addr[PH_W-2 -: OUT_W] : addr[PH_W-2 -: OUT_W];
        if (acc_clr)     st_d.smp = MID;
        else if (!sleep) st_d.smp = tri_mode ? tri_v : sine_v;
        sample = st_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{smp: MID};
        else        st_q <= st_d;
    end

    p_mid_after_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (sample == MID));

    p_sample_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !acc_clr) |=> $stable(sample));

    p_sine_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !sleep && !tri_mode) |=> (sample != '0));

endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core
    import dds_wave_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             freq_pin,
    input  logic             phase_pin,
    input  logic             acc_clr,
    input  logic             sleep,
    output logic [OUT_W-1:0] sample,
    output logic             sq_out
);

    logic [ACC_W-1:0] freq_word;
    logic [PH_W-1:0]  phase_word;
    ctrl_t            ctrl;
    logic [ACC_W-1:0] acc;

    dds_reg_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .freq_pin   (freq_pin),
        .phase_pin  (phase_pin),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .ctrl       (ctrl)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_clr   (acc_clr),
        .sleep     (sleep),
        .sq_div2   (ctrl.sq_div2),
        .freq_word (freq_word),
        .acc       (acc),
        .sq_out    (sq_out)
    );

    dds_wave_shaper #(.PH_W(PH_W), .OUT_W(OUT_W)) shaper_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_clr   (acc_clr),
        .sleep     (sleep),
        .tri_mode  (ctrl.tri_mode),
        .acc_top   (acc[ACC_W-1 -: PH_W]),
        .phase_off (phase_word),
        .sample    (sample)
    );

endmodule

// File: tb/dds_wave_core_tb.sv
module dds_wave_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;
    logic        freq_pin = 1'b0;
    logic        phase_pin = 1'b0;
    logic        acc_clr = 1'b0;
    logic        sleep = 1'b0;
    logic [9:0]  sample;
    logic        sq_out;

    always #4 clk = ~clk;

    dds_wave_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freq_pin(freq_pin), .phase_pin(phase_pin),
        .acc_clr(acc_clr), .sleep(sleep), .sample(sample), .sq_out(sq_out)
    );

    int errors = 0;
    int checks = 0;

    // reference state
    logic [27:0] m_f [2];
    logic [11:0] m_p [2];
    logic [15:0] m_ctrl;
    logic [27:0] m_acc;
    logic        m_tog, m_sq;
    int          m_smp;
    bit          m_sine;

    typedef struct packed {
        logic [27:0] f0;
        logic [27:0] f1;
        logic [11:0] p0;
        logic [11:0] p1;
        logic [15:0] ctrl;
        logic        fpin;
        logic        ppin;
        logic [15:0] ncyc;
        logic [7:0]  req;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{28'h2492492, 28'h0000000, 12'h000, 12'h000, 16'h0000, 1'b0, 1'b0, 16'd200, 8'd2}, // R2
        '{28'h0010000, 28'h0100000, 12'h000, 12'h000, 16'h0000, 1'b1, 1'b0, 16'd150, 8'd3}, // R3
        '{28'h0033333, 28'h0555555, 12'h000, 12'h000, 16'h0003, 1'b0, 1'b0, 16'd150, 8'd4}, // R4
        '{28'h0123456, 28'h0000000, 12'h000, 12'h400, 16'h0000, 1'b0, 1'b1, 16'd150, 8'd5}, // R5
        '{28'h0400000, 28'h0000000, 12'h000, 12'h000, 16'h0008, 1'b0, 1'b0, 16'd100, 8'd7}, // R7
        '{28'h1000000, 28'h0000000, 12'h000, 12'h000, 16'h0010, 1'b0, 1'b0, 16'd100, 8'd9}, // R9
        '{28'h00F0F0F, 28'h0000000, 12'h123, 12'h800, 16'h0005, 1'b0, 1'b0, 16'd150, 8'd4}, // R4 phase
        '{28'h8000000, 28'h0000000, 12'h000, 12'h000, 16'h0000, 1'b0, 1'b0, 16'd40,  8'd8}, // R8
        '{28'h0001000, 28'h0000000, 12'h000, 12'h000, 16'h0000, 1'b0, 1'b0, 16'd600, 8'd6}  // R6
    };

    function automatic int exp_wave(logic [11:0] p, logic tri_m);
        real r;
        if (tri_m) return p[11] ? int'(~p[10:1]) & 10'h3FF : int'(p[10:1]);
        r = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0);
        return 512 + $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic model_reset();
        m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0;
        m_ctrl = '0; m_acc = '0; m_tog = 1'b0; m_sq = 1'b0;
        m_smp = 512; m_sine = 1'b0;
    endtask

    task automatic step();
        logic        fs, ps;
        logic [27:0] nacc;
        logic [11:0] pidx;
        @(posedge clk);
        fs   = m_ctrl[0] ? m_ctrl[1] : freq_pin;
        ps   = m_ctrl[0] ? m_ctrl[2] : phase_pin;
        nacc = m_acc + m_f[fs];
        if (acc_clr) begin
            m_acc = '0; m_tog = 1'b0; m_sq = 1'b0; m_smp = 512; m_sine = 1'b0;
        end else if (!sleep) begin
            pidx   = m_acc[27:16] + m_p[ps];
            m_smp  = exp_wave(pidx, m_ctrl[3]);
            m_sine = !m_ctrl[3];
            m_sq   = m_ctrl[4] ? m_tog : m_acc[27];
            m_tog  = m_tog ^ (!m_acc[27] && nacc[27]);
            m_acc  = nacc;
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_f[0] = wr_data;
                3'd1: m_f[1] = wr_data;
                3'd2: m_p[0] = wr_data[11:0];
                3'd3: m_p[1] = wr_data[11:0];
                3'd4: m_ctrl = wr_data[15:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic chk(string tag);
        int diff;
        int tol;
        diff = int'(sample) - m_smp;
        tol  = m_sine ? 2 : 0;
        checks++;
        if (diff > tol || diff < -tol) begin
            errors++;
            $display("FAIL %s sample: actual=%0d expected=%0d", tag, sample, m_smp);
        end
        checks++;
        if (sq_out !== m_sq) begin
            errors++;
            $display("FAIL %s sq_out: actual=%0b expected=%0b", tag, sq_out, m_sq);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [27:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [9:0] held;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 in reset");
        rst_n = 1'b1;
        // R1: stored words are zero, so output stays at mid-scale
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R1 after reset");
        end

        // R12: writes via every address, table walk for R2..R9
        for (int r = 0; r < NROWS; r++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", ROWS[r].req, r);
            wr(3'd0, ROWS[r].f0);
            wr(3'd1, ROWS[r].f1);
            wr(3'd2, {16'h0, ROWS[r].p0});
            wr(3'd3, {16'h0, ROWS[r].p1});
            wr(3'd4, {12'h0, ROWS[r].ctrl});
            freq_pin  = ROWS[r].fpin;
            phase_pin = ROWS[r].ppin;
            acc_clr = 1'b1; step(); acc_clr = 1'b0;
            chk({tag, " clr"});
            for (int c = 0; c < int'(ROWS[r].ncyc); c++) begin
                step();
                chk(tag);
            end
        end

        // R3: pins toggled each cycle, pin sampled at its own edge
        wr(3'd0, 28'h0200000);
        wr(3'd1, 28'h0040000);
        wr(3'd2, 28'h0000010);
        wr(3'd3, 28'h0000C00);
        wr(3'd4, 28'h0);
        for (int c = 0; c < 80; c++) begin
            freq_pin  = c[0];
            phase_pin = c[1];
            step();
            chk("R3 keying");
        end

        // R4: pins ignored when software selects
        wr(3'd4, 28'h0000007);
        for (int c = 0; c < 60; c++) begin
            freq_pin  = c[0];
            phase_pin = ~c[0];
            step();
            chk("R4 pins ignored");
        end
        wr(3'd4, 28'h0);
        freq_pin = 1'b0; phase_pin = 1'b0;

        // R11: sleep holds, then resumes from held phase
        for (int c = 0; c < 17; c++) step();
        held  = sample;
        sleep = 1'b1;
        for (int c = 0; c < 12; c++) begin
            step();
            chk("R11 sleeping");
            checks++;
            if (sample !== held) begin
                errors++;
                $display("FAIL R11 hold: actual=%0d expected=%0d", sample, held);
            end
        end
        sleep = 1'b0;
        for (int c = 0; c < 30; c++) begin
            step();
            chk("R11 resumed");
        end

        // R10: clear wins over sleep; words kept
        sleep = 1'b1; acc_clr = 1'b1;
        step();
        chk("R10 clr over sleep");
        checks++;
        if (sample !== 10'd512) begin
            errors++;
            $display("FAIL R10 midscale: actual=%0d expected=512", sample);
        end
        acc_clr = 1'b0;
        step();
        chk("R10 held at mid");
        sleep = 1'b0;
        for (int c = 0; c < 40; c++) begin
            step();
            chk("R10 words kept");
        end

        // R12: unused addresses change nothing, write during sleep lands
        wr(3'd5, 28'hFFFFFFF);
        wr(3'd6, 28'hFFFFFFF);
        wr(3'd7, 28'hFFFFFFF);
        for (int c = 0; c < 40; c++) begin
            step();
            chk("R12 unused addr");
        end
        sleep = 1'b1;
        wr(3'd0, 28'h0777777);
        sleep = 1'b0;
        for (int c = 0; c < 40; c++) begin
            step();
            chk("R12 write in sleep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule